// File: doc/BRIEF.md
# Fixed-Latency Sync Command Inserter

This block lives in a link aggregator that feeds a word-framed serial link toward front-end boards. A train-start pulse arrives at an arbitrary moment relative to the outgoing word stream. The block can first bring the pulse into the local clock domain through a configurable synchroniser chain. It then notes which bit slot of the current outgoing word was being serialised when the pulse was captured. At the next word boundary it replaces the normal data word with a synchronisation command. The upper byte of that command is a control (K) character. The lower byte carries a command type and a delay count.

The delay count is chosen so that the slot count from capture to the word boundary, plus the delay, always equals a fixed base latency. A receiver that waits the delay count after the command word therefore acts a constant number of slots after the original pulse, wherever in the word the pulse fell. The data word that the command displaced is discarded, and a one-cycle flag reports the loss. A further pulse that arrives while a command is still waiting to go out is ignored and reported on a one-cycle overrun flag.

The serialiser drives the bit-slot counter and the word strobe. The counter advances by one slot per clock, and the strobe is high in the last slot of each word. In that cycle the block loads the next outgoing word into its output register.

Top module: `scmd_inserter`

## Requirements
- R1: While reset is held, and after it until the first word strobe, data_out, k_out, drop_flag and overrun_flag are all zero.
- R2: On a word strobe with no command waiting, data_out and k_out take data_in and k_in one clock later. Between strobes both outputs hold their value.
- R3: A rising edge of sync_in first seen at clock edge n is captured at edge n+SYNC_STAGES. The bit_cnt value sampled at that capture edge is the recorded arrival slot.
- R4: The first word strobe after a capture emits a command word instead of data. In it, data_out[15:8] = K_CODE and k_out = 2'b10 (bit 1 flags the upper byte as a control character, bit 0 flags the lower byte as data).
- R5: The command delay field, data_out[5:0], equals BASE_LAT minus the number of clock edges from the capture edge to the inserting strobe edge. For arrival slot p that count is SLOTS-1-p when p < SLOTS-1, and SLOTS when p = SLOTS-1.
- R6: The command type field, data_out[7:6], is the type_cfg value sampled at the capture edge. Later changes of type_cfg do not alter the waiting command.
- R7: drop_flag is high for exactly the one cycle in which the command word first appears on data_out, and is low otherwise.
- R8: A capture that happens while a command is still waiting, including at the inserting strobe edge itself, raises overrun_flag for one cycle. It leaves the waiting command's type and delay unchanged and creates no second command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast link clock, one bit slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_in | input | 1 | Train-start pulse, level sampled for a rising edge |
| type_cfg | input | 2 | Command type to place in the next captured command |
| bit_cnt | input | 5 | Bit slot currently being serialised, 0 to SLOTS-1 |
| word_strobe | input | 1 | High in the last slot of each word; loads the next word |
| data_in | input | 16 | Normal outgoing data word |
| k_in | input | 2 | Per-byte control flags of data_in, bit 1 for the upper byte |
| data_out | output | 16 | Word handed to the serialiser |
| k_out | output | 2 | Per-byte control flags of data_out |
| drop_flag | output | 1 | One-cycle pulse: a data word was displaced by a command |
| overrun_flag | output | 1 | One-cycle pulse: a pulse was ignored because a command was waiting |

## Verification
The assertions assume that bit_cnt advances by one slot per clock and wraps at SLOTS. They also assume that word_strobe is high exactly when bit_cnt is in the last slot, so strobes are SLOTS cycles apart and a command can never sit on the output two cycles running. The stimulus drives bit_cnt from a free-running wrap counter and derives the strobe from it. It holds each sync_in pulse high for two cycles and low for at least two, so the synchroniser sees every edge. Pulses are placed at chosen slots (first, last, next-to-last, middle, and on the strobe slot while a command waits) to reach each delay and overrun corner.

// File: rtl/scmd_pkg.sv
package scmd_pkg;
  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int TYPE_W  = 2;
  localparam int DELAY_W = 6;

  typedef struct packed {
    logic [BYTE_W-1:0]  kchar;
    logic [TYPE_W-1:0]  ctype;
    logic [DELAY_W-1:0] delay;
  } sync_cmd_t;

  typedef logic [1:0] kflags_t;

  // control flag on the upper byte only
  localparam kflags_t CMD_KFLAGS = 2'b10;

  function automatic logic [WORD_W-1:0] pack_cmd(input sync_cmd_t c);
    return {c.kchar, c.ctype, c.delay};
  endfunction
endpackage

// File: rtl/scmd_pulse_sync.sv
module scmd_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic capture_o
);
  logic level;
  logic prev_q;

  generate
    if (STAGES == 0) begin : g_direct
      assign level = async_in;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;

      always_comb begin
        chain_d = {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0:0], async_in};
        if (STAGES == 1) chain_d[0] = async_in;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end

      assign level = chain_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign capture_o = level & ~prev_q;
endmodule

// File: rtl/scmd_arrival_track.sv
module scmd_arrival_track
  import scmd_pkg::*;
#(
  parameter int          SLOTS    = 20,
  parameter int          BASE_LAT = 48,
  parameter logic [7:0]  K_CODE   = 8'h3C
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         capture_i,
  input  logic                         word_strobe_i,
  input  logic [$clog2(SLOTS)-1:0]     bit_cnt_i,
  input  logic [TYPE_W-1:0]            type_cfg_i,
  output logic                         pending_o,
  output sync_cmd_t                    cmd_o,
  output logic                         overrun_o
);
  localparam int CNT_W = $clog2(SLOTS);
  localparam logic [CNT_W-1:0]   LAST_V = CNT_W'(SLOTS - 1);
  localparam logic [DELAY_W-1:0] BASE_V = DELAY_W'(BASE_LAT);
  localparam logic [DELAY_W-1:0] FULL_V = DELAY_W'(SLOTS);

  logic              pending_q, pending_d;
  logic [CNT_W-1:0]  pos_q;
  logic [TYPE_W-1:0] type_q;
  logic              ovr_q, ovr_d;
  logic              load_en;
  logic [DELAY_W-1:0] elapsed;

  // next-state
  always_comb begin
    pending_d = pending_q;
    ovr_d     = 1'b0;
    load_en   = 1'b0;
    if (word_strobe_i && pending_q) pending_d = 1'b0;
    if (capture_i) begin
      if (pending_q) begin
        ovr_d = 1'b1;
      end else begin
        pending_d = 1'b1;
        load_en   = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      pending_q <= pending_d;
      ovr_q     <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      type_q <= '0;
    end else if (load_en) begin
      pos_q  <= bit_cnt_i;
      type_q <= type_cfg_i;
    end
  end

  // slots from capture to the inserting strobe
  always_comb begin
    if (pos_q == LAST_V) elapsed = FULL_V;
    else                 elapsed = DELAY_W'(LAST_V - pos_q);
  end

  always_comb begin
    cmd_o.kchar = K_CODE;
    cmd_o.ctype = type_q;
    cmd_o.delay = BASE_V - elapsed;
  end

  assign pending_o = pending_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/scmd_word_mux.sv
module scmd_word_mux
  import scmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_strobe_i,
  input  logic              pending_i,
  input  sync_cmd_t         cmd_i,
  input  logic [WORD_W-1:0] data_i,
  input  kflags_t           k_i,
  output logic [WORD_W-1:0] data_o,
  output kflags_t           k_o,
  output logic              drop_o
);
  logic [WORD_W-1:0] word_q, word_d;
  kflags_t           k_q, k_d;
  logic              drop_q, drop_d;

  always_comb begin
    if (pending_i) begin
      word_d = pack_cmd(cmd_i);
      k_d    = CMD_KFLAGS;
    end else begin
      word_d = data_i;
      k_d    = k_i;
    end
    drop_d = word_strobe_i & pending_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      k_q    <= '0;
    end else if (word_strobe_i) begin
      word_q <= word_d;
      k_q    <= k_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_q <= 1'b0;
    else        drop_q <= drop_d;
  end

  assign data_o = word_q;
  assign k_o    = k_q;
  assign drop_o = drop_q;
endmodule

// File: rtl/scmd_inserter.sv
module scmd_inserter
  import scmd_pkg::*;
#(
  parameter int         SLOTS       = 20,
  parameter int         BASE_LAT    = 48,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] K_CODE      = 8'h3C
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sync_in,
  input  logic [1:0]                type_cfg,
  input  logic [$clog2(SLOTS)-1:0]  bit_cnt,
  input  logic                      word_strobe,
  input  logic [15:0]               data_in,
  input  logic [1:0]                k_in,
  output logic [15:0]               data_out,
  output logic [1:0]                k_out,
  output logic                      drop_flag,
  output logic                      overrun_flag
);
  logic      rst_meta_q, rst_sync_q;
  logic      capture;
  logic      pending;
  sync_cmd_t cmd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  scmd_pulse_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .async_in  (sync_in),
    .capture_o (capture)
  );

  scmd_arrival_track #(
    .SLOTS    (SLOTS),
    .BASE_LAT (BASE_LAT),
    .K_CODE   (K_CODE)
  ) track_i (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .capture_i     (capture),
    .word_strobe_i (word_strobe),
    .bit_cnt_i     (bit_cnt),
    .type_cfg_i    (type_cfg),
    .pending_o     (pending),
    .cmd_o         (cmd),
    .overrun_o     (overrun_flag)
  );

  scmd_word_mux mux_i (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .word_strobe_i (word_strobe),
    .pending_i     (pending),
    .cmd_i         (cmd),
    .data_i        (data_in),
    .k_i           (k_in),
    .data_o        (data_out),
    .k_o           (k_out),
    .drop_o        (drop_flag)
  );
endmodule

// File: rtl/scmd_inserter_chk.sv
module scmd_inserter_chk #(
  parameter int         SLOTS    = 20,
  parameter int         BASE_LAT = 48,
  parameter logic [7:0] K_CODE   = 8'h3C
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [$clog2(SLOTS)-1:0] bit_cnt,
  input logic                     word_strobe,
  input logic [15:0]              data_out,
  input logic [1:0]               k_out,
  input logic                     drop_flag,
  input logic                     overrun_flag
);
  localparam int CNT_W = $clog2(SLOTS);
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(SLOTS - 1);
  localparam logic [5:0] DLY_MIN = 6'(BASE_LAT - SLOTS);
  localparam logic [5:0] DLY_MAX = 6'(BASE_LAT - 1);

  // input contract used by the R2 hold and R7 single-cycle checks
  assert_strobe_in_last_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_strobe |-> (bit_cnt == LAST_V));

  assert_output_held_between_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !word_strobe |=> ($stable(data_out) && $stable(k_out)));

  assert_drop_marks_command_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_flag |-> (k_out == 2'b10 && data_out[15:8] == K_CODE));

  assert_delay_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drop_flag |-> (data_out[5:0] >= DLY_MIN && data_out[5:0] <= DLY_MAX));

  assert_drop_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_flag |=> !drop_flag);

  assert_overrun_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_flag |=> !overrun_flag);
endmodule

bind scmd_inserter scmd_inserter_chk #(
  .SLOTS    (SLOTS),
  .BASE_LAT (BASE_LAT),
  .K_CODE   (K_CODE)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_cnt      (bit_cnt),
  .word_strobe  (word_strobe),
  .data_out     (data_out),
  .k_out        (k_out),
  .drop_flag    (drop_flag),
  .overrun_flag (overrun_flag)
);

// File: tb/scmd_inserter_tb_top.sv
module scmd_inserter_tb_top;
  localparam int         SLOTS       = 20;
  localparam int         BASE_LAT    = 48;
  localparam int         SYNC_STAGES = 2;
  localparam logic [7:0] K_CODE      = 8'h3C;
  localparam int         CNT_W       = $clog2(SLOTS);

  logic             clk;
  logic             rst_n;
  logic             sync_in;
  logic [1:0]       type_cfg;
  logic [CNT_W-1:0] bit_cnt;
  logic             word_strobe;
  logic [15:0]      data_in;
  logic [1:0]       k_in;
  logic [15:0]      data_out;
  logic [1:0]       k_out;
  logic             drop_flag;
  logic             overrun_flag;

  scmd_inserter #(
    .SLOTS(SLOTS), .BASE_LAT(BASE_LAT), .SYNC_STAGES(SYNC_STAGES), .K_CODE(K_CODE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .type_cfg(type_cfg),
    .bit_cnt(bit_cnt), .word_strobe(word_strobe), .data_in(data_in), .k_in(k_in),
    .data_out(data_out), .k_out(k_out), .drop_flag(drop_flag), .overrun_flag(overrun_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state
  int         bc = 0;
  int         edge_n = 0;
  bit         raw_prev = 0;
  int         cap_q[$];
  bit         pend = 0;
  int         pend_edge = 0;
  logic [1:0] pend_type = 0;
  logic [1:0] cur_cfg = 0;
  logic [15:0] exp_data = 0;
  logic [1:0]  exp_k = 0;
  bit          exp_cmd = 0;
  bit          exp_drop = 0;
  bit          exp_ovr = 0;
  int          n_cmds = 0;
  int          n_ovr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    if (exp_cmd) begin
      chk(k_out == 2'b10 && data_out[15:8] == K_CODE, "R4 command K byte",
          {k_out, data_out[15:8]}, {2'b10, K_CODE});
      chk(data_out[7:6] == exp_data[7:6], "R6 command type", data_out[7:6], exp_data[7:6]);
      chk(data_out[5:0] == exp_data[5:0], "R3 R5 command delay", data_out[5:0], exp_data[5:0]);
    end else begin
      chk(data_out == exp_data && k_out == exp_k, "R2 pass-through word",
          {k_out, data_out}, {exp_k, exp_data});
    end
    chk(drop_flag == exp_drop, "R7 drop flag", drop_flag, exp_drop);
    chk(overrun_flag == exp_ovr, "R8 overrun flag", overrun_flag, exp_ovr);
  endtask

  // one clock: check the outputs of the last edge, drive, and predict the next edge
  task automatic tick(input bit raw);
    bit         strobe;
    bit         capnow;
    bit         old_pend;
    logic [15:0] din;
    logic [1:0]  kin;
    @(negedge clk);
    compare();
    strobe = (bc == SLOTS - 1);
    din = 16'(edge_n * 40503 + 12345);
    kin = (edge_n % 7 == 0) ? 2'b01 : 2'b00;
    sync_in     = raw;
    type_cfg    = cur_cfg;
    bit_cnt     = CNT_W'(bc);
    word_strobe = strobe;
    data_in     = din;
    k_in        = kin;

    if (raw && !raw_prev) cap_q.push_back(edge_n + SYNC_STAGES);
    raw_prev = raw;
    capnow = 0;
    if (cap_q.size() > 0 && cap_q[0] == edge_n) begin
      capnow = 1;
      void'(cap_q.pop_front());
    end
    old_pend = pend;
    exp_drop = 0;
    exp_ovr  = 0;
    if (strobe) begin
      if (old_pend) begin
        exp_data = {K_CODE, pend_type, 6'(BASE_LAT - (edge_n - pend_edge))};
        exp_k    = 2'b10;
        exp_cmd  = 1;
        exp_drop = 1;
        pend     = 0;
        n_cmds++;
      end else begin
        exp_data = din;
        exp_k    = kin;
        exp_cmd  = 0;
      end
    end
    if (capnow) begin
      if (old_pend) begin
        exp_ovr = 1;
        n_ovr++;
      end else begin
        pend      = 1;
        pend_edge = edge_n;
        pend_type = cur_cfg;
      end
    end
    bc = (bc + 1) % SLOTS;
    edge_n++;
  endtask

  // raise sync_in so that its capture edge samples bit_cnt == p
  task automatic sync_at(input int p);
    int target;
    target = ((p - SYNC_STAGES) % SLOTS + SLOTS) % SLOTS;
    while (bc != target) tick(0);
    tick(1);
    tick(1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sync_in = 0; type_cfg = 0; bit_cnt = '0;
    word_strobe = 0; data_in = 16'hFFFF; k_in = 2'b11;
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk(data_out == 16'h0 && k_out == 2'b00, "R1 reset word", {k_out, data_out}, 0);
    chk(!drop_flag && !overrun_flag, "R1 reset flags", {drop_flag, overrun_flag}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    data_in = 16'h0; k_in = 2'b00;
    chk(data_out == 16'h0 && k_out == 2'b00, "R1 after release", {k_out, data_out}, 0);

    idle(3 * SLOTS);                 // R2 pass-through only
    cur_cfg = 2'd1;
    sync_at(0);                      // R5 slot 0, elapsed SLOTS-1
    cur_cfg = 2'd2;                  // R6 change while pending
    idle(2 * SLOTS);
    cur_cfg = 2'd3;
    sync_at(SLOTS - 1);              // R5 last slot, elapsed SLOTS
    idle(2 * SLOTS);
    cur_cfg = 2'd0;
    sync_at(SLOTS - 2);              // R5 elapsed 1
    idle(2 * SLOTS);
    cur_cfg = 2'd2;
    sync_at(7);
    idle(2 * SLOTS);
    cur_cfg = 2'd1;
    sync_at(2);                      // R8 overrun in same word
    cur_cfg = 2'd3;
    sync_at(10);
    idle(2 * SLOTS);
    cur_cfg = 2'd2;
    sync_at(5);                      // R8 capture on the inserting strobe edge
    cur_cfg = 2'd0;
    sync_at(SLOTS - 1);
    idle(3 * SLOTS);
    chk(n_cmds == 6, "R4 commands issued", n_cmds, 6);
    chk(n_ovr == 2, "R8 overruns seen", n_ovr, 2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule